// File: doc/BRIEF.md
# Instruction fetch-and-align buffer

This block sits between an instruction cache and a three-lane decoder. It takes in aligned 32-byte blocks of instruction bytes, each with one end-of-instruction marker bit per byte, and keeps them in a 64-byte byte queue. In every cycle it cuts up to three variable-length instructions from the head of the queue and places them on three decoder lanes. Lane 0 carries the oldest instruction. The decoder takes whatever is presented in that cycle, so any bytes shown on a valid lane leave the queue at the next clock edge. A 32-byte fetch width keeps three instructions of up to nine bytes flowing in every cycle, even when they cross block boundaries.

The cache interface works as a request/response pair within one cycle. The block raises `fetchReq` with an aligned `fetchAddr` when the queue has room. The cache answers in the same cycle with `fetchValid`, the data and the markers. A block is taken when both `fetchReq` and `fetchValid` are high. A redirect empties the queue and restarts fetch at a new target. When the target is not aligned, the leading bytes of the first block are thrown away.

Top module: `fetch_align_buf`

## Requirements
- R1: After reset, and until the first redirect, `fetchReq` stays low and no lane is valid, whatever the cache drives.
- R2: In a cycle with `redirectValid` high, `fetchReq` is low, every lane is invalid and cache data is ignored. The queue is empty in the next cycle, so no lane is valid then.
- R3: After a redirect to a target whose low five bits are non-zero, the bytes below that offset in the first accepted block are discarded, and the first instruction emitted starts at the target byte.
- R4: The block after a redirect is fetched from the target with its low five bits cleared. `fetchAddr` rises by 32 after each accepted block (`fetchReq` and `fetchValid` both high) and holds its value otherwise. It is always 32-byte aligned while `fetchReq` is high.
- R5: Once running and outside a redirect cycle, `fetchReq` is high exactly when the number of queued bytes, minus the bytes emitted on the lanes this cycle, is at most 32. With one-byte instructions the queue fills and `fetchReq` falls.
- R6: An instruction ends at the first byte, counting from its first byte, whose marker bit is 1. If none of its first nine bytes is marked, it ends after nine bytes.
- R7: A lane is valid only when every byte of its instruction is already in the queue. An instruction that is still missing bytes leaves its lane, and every later lane, invalid.
- R8: Lanes fill in program order with no gaps. Lane 0 holds the oldest instruction, lane 1 the next and lane 2 the one after that. Emitted bytes are removed, so each instruction appears exactly once.
- R9: Each valid lane gives a 4-bit length and a 16-byte field. Instruction byte k sits at bits [8k+7:8k], and bytes at or beyond the length read as zero. In the flattened ports, lane i occupies `laneLen[4i+3:4i]` and `laneBytes[128i+127:128i]`. Fetch byte k arrives at `fetchData[8k+7:8k]` and its marker at `fetchEnd[k]`.
- R10: An instruction whose bytes span two consecutive fetch blocks comes out with its bytes joined in address order.
- R11: With nine-byte instructions, an aligned target and no cache stalls, all three lanes are valid in every cycle from the first cycle that emits anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| redirectValid | input | 1 | Flush the queue and restart fetch |
| redirectAddr | input | 32 | Byte address of the redirect target |
| fetchReq | output | 1 | Request for the block at `fetchAddr` |
| fetchAddr | output | 32 | Aligned address of the requested block |
| fetchValid | input | 1 | Cache supplies the requested block this cycle |
| fetchData | input | 256 | Block bytes, byte k at bits [8k+7:8k] |
| fetchEnd | input | 32 | End-of-instruction marker per byte |
| laneValid | output | 3 | Per-lane instruction valid |
| laneLen | output | 12 | Per-lane 4-bit instruction length |
| laneBytes | output | 384 | Per-lane 16-byte instruction field, zero padded |

## Verification
The bench goes after redirects to targets at offsets 0, 5, 11, 25, 31 and 7. A design that ignores the offset would emit the decoy one-byte instructions marked below the target, and one that mixes up the byte shift would put the wrong bytes at the start of the first lane. Cache stalls every third or every other cycle check that the fetch address holds still. A design that advances it anyway would skip a block, and the bytes seen on the lanes would show the missing stretch. One-byte instructions push the queue to full, where a wrong free-space test would either overwrite queued bytes or never drop `fetchReq`. Marker gaps of thirteen bytes check the nine-byte cap, and nine-byte runs check both block-boundary joining and the three-per-cycle rate. A queue that under-fetches would drop a lane in some cycle.

// File: rtl/fetch_align_pkg.sv
package fetch_align_pkg;

  // Default fetch width shared by all submodules; the skip field below is sized from it.
  localparam int FAB_FETCH_BYTES = 32;
  localparam int FAB_OFF_W       = $clog2(FAB_FETCH_BYTES);

  // Strobes from the control to the datapath, valid for the current cycle.
  typedef struct packed {
    logic                 flush;    // redirect: drop the queue, hide the lanes
    logic                 push;     // a fetch block is taken this cycle
    logic [FAB_OFF_W-1:0] skipOff;  // leading bytes of that block to drop
  } fabStrobe_t;

endpackage

// File: rtl/fab_lane_pick.sv
module fab_lane_pick #(
  parameter int MAX_INSN = 9,
  parameter int LEN_W    = 4,
  parameter int CNT_W    = 7
) (
  input  logic [MAX_INSN-1:0] endWin,
  input  logic [CNT_W-1:0]    avail,
  input  logic                prevOk,
  output logic [LEN_W-1:0]    len,
  output logic                ok
);

  // Lowest marked byte wins; with no mark the instruction is capped at MAX_INSN.
  always_comb begin
    len = LEN_W'(MAX_INSN);
    for (int k = MAX_INSN - 1; k >= 0; k--) begin
      if (endWin[k]) len = LEN_W'(k + 1);
    end
    ok = prevOk && (CNT_W'(len) <= avail);
  end

endmodule

// File: rtl/fab_datapath.sv
module fab_datapath
  import fetch_align_pkg::*;
#(
  parameter int FETCH_BYTES = FAB_FETCH_BYTES,
  parameter int QUEUE_BYTES = 64,
  parameter int LANES       = 3,
  parameter int MAX_INSN    = 9,
  parameter int LANE_BYTES  = 16,
  parameter int LEN_W       = $clog2(LANE_BYTES),
  parameter int CNT_W       = $clog2(QUEUE_BYTES + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fabStrobe_t                    strobe,
  input  logic [FETCH_BYTES*8-1:0]      fetchData,
  input  logic [FETCH_BYTES-1:0]        fetchEnd,
  output logic [CNT_W-1:0]              qCount,
  output logic [CNT_W-1:0]              popBytes,
  output logic [LANES-1:0]              laneValid,
  output logic [LANES*LEN_W-1:0]        laneLen,
  output logic [LANES*LANE_BYTES*8-1:0] laneBytes
);

  localparam int QIDX_W = $clog2(QUEUE_BYTES);
  localparam int FIDX_W = $clog2(FETCH_BYTES);

  logic [7:0]             qByte [QUEUE_BYTES];
  logic [QUEUE_BYTES-1:0] qEnd;
  logic [7:0]             nByte [QUEUE_BYTES];
  logic [QUEUE_BYTES-1:0] nEnd;
  logic [CNT_W-1:0]       nCount;

  logic [CNT_W-1:0] laneStart [LANES+1];
  logic [LEN_W-1:0] pickLen   [LANES];
  logic [LANES:0]   okChain;

  assign laneStart[0] = '0;
  assign okChain[0]   = 1'b1;

  // One slicer per lane; each lane starts where the previous one ended.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [MAX_INSN-1:0]     win;
    logic [CNT_W-1:0]        avail;
    logic [LANE_BYTES*8-1:0] laneData;

    always_comb begin
      int idx;
      idx = 0;
      for (int k = 0; k < MAX_INSN; k++) begin
        idx    = int'(laneStart[g]) + k;
        win[k] = (idx < QUEUE_BYTES) ? qEnd[idx[QIDX_W-1:0]] : 1'b0;
      end
    end

    assign avail = (qCount > laneStart[g]) ? qCount - laneStart[g] : '0;

    fab_lane_pick #(
      .MAX_INSN(MAX_INSN),
      .LEN_W   (LEN_W),
      .CNT_W   (CNT_W)
    ) uPick (
      .endWin(win),
      .avail (avail),
      .prevOk(okChain[g]),
      .len   (pickLen[g]),
      .ok    (okChain[g+1])
    );

    assign laneStart[g+1] = laneStart[g] + CNT_W'(pickLen[g]);

    always_comb begin
      int idx;
      idx      = 0;
      laneData = '0;
      for (int k = 0; k < LANE_BYTES; k++) begin
        idx = int'(laneStart[g]) + k;
        if (k < int'(pickLen[g]) && idx < QUEUE_BYTES)
          laneData[k*8 +: 8] = qByte[idx[QIDX_W-1:0]];
      end
    end

    assign laneValid[g] = okChain[g+1] & ~strobe.flush;
    assign laneLen[g*LEN_W +: LEN_W] = pickLen[g];
    assign laneBytes[g*LANE_BYTES*8 +: LANE_BYTES*8] = laneData;
  end

  always_comb begin
    popBytes = '0;
    for (int g = 0; g < LANES; g++) begin
      if (laneValid[g]) popBytes = popBytes + CNT_W'(pickLen[g]);
    end
  end

  // Next queue image: survivors slide to the head, the new block lands behind them.
  always_comb begin
    int remain;
    int pushLen;
    int src;
    remain  = int'(qCount) - int'(popBytes);
    pushLen = strobe.push ? FETCH_BYTES - int'(strobe.skipOff) : 0;
    src     = 0;
    for (int i = 0; i < QUEUE_BYTES; i++) begin
      nByte[i] = '0;
      nEnd[i]  = 1'b0;
      if (i < remain) begin
        src = i + int'(popBytes);
        if (src < QUEUE_BYTES) begin
          nByte[i] = qByte[src[QIDX_W-1:0]];
          nEnd[i]  = qEnd[src[QIDX_W-1:0]];
        end
      end else if (i < remain + pushLen) begin
        src = i - remain + int'(strobe.skipOff);
        if (src >= 0 && src < FETCH_BYTES) begin
          nByte[i] = fetchData[src*8 +: 8];
          nEnd[i]  = fetchEnd[src[FIDX_W-1:0]];
        end
      end
    end
    nCount = strobe.flush ? '0 : CNT_W'(remain + pushLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qCount <= '0;
    else       qCount <= nCount;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < QUEUE_BYTES; i++) qByte[i] <= nByte[i];
    qEnd <= nEnd;
  end

endmodule

// File: rtl/fab_control.sv
module fab_control
  import fetch_align_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = FAB_FETCH_BYTES,
  parameter int QUEUE_BYTES = 64,
  parameter int CNT_W       = $clog2(QUEUE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirectValid,
  input  logic [ADDR_W-1:0] redirectAddr,
  input  logic              fetchValid,
  input  logic [CNT_W-1:0]  qCount,
  input  logic [CNT_W-1:0]  popBytes,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output fabStrobe_t        strobe
);

  localparam int               OFF_W     = FAB_OFF_W;
  localparam logic [CNT_W-1:0] REQ_LIMIT = CNT_W'(QUEUE_BYTES - FETCH_BYTES);

  logic              running;
  logic              skipPend;
  logic [OFF_W-1:0]  skipReg;
  logic [ADDR_W-1:0] fetchPtr;
  logic [CNT_W-1:0]  afterPop;

  assign afterPop  = qCount - popBytes;
  assign fetchReq  = running & ~redirectValid & (afterPop <= REQ_LIMIT);
  assign fetchAddr = fetchPtr;

  assign strobe.flush   = redirectValid;
  assign strobe.push    = fetchReq & fetchValid;
  assign strobe.skipOff = skipPend ? skipReg : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      skipPend <= 1'b0;
      skipReg  <= '0;
      fetchPtr <= '0;
    end else if (redirectValid) begin
      running  <= 1'b1;
      skipPend <= 1'b1;
      skipReg  <= redirectAddr[OFF_W-1:0];
      fetchPtr <= {redirectAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else if (strobe.push) begin
      skipPend <= 1'b0;
      fetchPtr <= fetchPtr + ADDR_W'(FETCH_BYTES);
    end
  end

endmodule

// File: rtl/fetch_align_buf.sv
module fetch_align_buf
  import fetch_align_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = FAB_FETCH_BYTES,
  parameter int QUEUE_BYTES = 64,
  parameter int LANES       = 3,
  parameter int MAX_INSN    = 9,
  parameter int LANE_BYTES  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          redirectValid,
  input  logic [ADDR_W-1:0]             redirectAddr,
  output logic                          fetchReq,
  output logic [ADDR_W-1:0]             fetchAddr,
  input  logic                          fetchValid,
  input  logic [FETCH_BYTES*8-1:0]      fetchData,
  input  logic [FETCH_BYTES-1:0]        fetchEnd,
  output logic [LANES-1:0]              laneValid,
  output logic [LANES*$clog2(LANE_BYTES)-1:0] laneLen,
  output logic [LANES*LANE_BYTES*8-1:0] laneBytes
);

  localparam int LEN_W = $clog2(LANE_BYTES);
  localparam int CNT_W = $clog2(QUEUE_BYTES + 1);

  fabStrobe_t       strobe;
  logic [CNT_W-1:0] qCount;
  logic [CNT_W-1:0] popBytes;

  fab_control #(
    .ADDR_W     (ADDR_W),
    .FETCH_BYTES(FETCH_BYTES),
    .QUEUE_BYTES(QUEUE_BYTES),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .redirectValid(redirectValid),
    .redirectAddr (redirectAddr),
    .fetchValid   (fetchValid),
    .qCount       (qCount),
    .popBytes     (popBytes),
    .fetchReq     (fetchReq),
    .fetchAddr    (fetchAddr),
    .strobe       (strobe)
  );

  fab_datapath #(
    .FETCH_BYTES(FETCH_BYTES),
    .QUEUE_BYTES(QUEUE_BYTES),
    .LANES      (LANES),
    .MAX_INSN   (MAX_INSN),
    .LANE_BYTES (LANE_BYTES),
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fetchData(fetchData),
    .fetchEnd (fetchEnd),
    .qCount   (qCount),
    .popBytes (popBytes),
    .laneValid(laneValid),
    .laneLen  (laneLen),
    .laneBytes(laneBytes)
  );

endmodule

// File: rtl/fab_checker.sv
module fab_checker #(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = 32,
  parameter int LANES       = 3,
  parameter int LEN_W       = 4,
  parameter int MAX_INSN    = 9
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   redirectValid,
  input logic                   fetchReq,
  input logic                   fetchValid,
  input logic [ADDR_W-1:0]      fetchAddr,
  input logic [LANES-1:0]       laneValid,
  input logic [LANES*LEN_W-1:0] laneLen
);

  localparam int OFF_W = $clog2(FETCH_BYTES);

  logic gapFree;
  always_comb begin
    gapFree = 1'b1;
    for (int g = 1; g < LANES; g++) begin
      if (laneValid[g] && !laneValid[g-1]) gapFree = 1'b0;
    end
  end

  // R8
  lane_order_chk: assert property (@(posedge clk) disable iff (!rstN) gapFree);

  // R2
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (!fetchReq && laneValid == '0));

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (laneValid == '0));

  // R4
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchAddr[OFF_W-1:0] == '0));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchValid) |=> $stable(fetchAddr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchValid) |=> (fetchAddr == $past(fetchAddr) + ADDR_W'(FETCH_BYTES)));

  for (genvar g = 0; g < LANES; g++) begin : gLen
    // R6
    lane_len_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneValid[g] |-> (laneLen[g*LEN_W +: LEN_W] != '0 &&
                        laneLen[g*LEN_W +: LEN_W] <= LEN_W'(MAX_INSN)));
  end

endmodule

bind fetch_align_buf fab_checker #(
  .ADDR_W     (ADDR_W),
  .FETCH_BYTES(FETCH_BYTES),
  .LANES      (LANES),
  .LEN_W      (LEN_W),
  .MAX_INSN   (MAX_INSN)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .redirectValid(redirectValid),
  .fetchReq     (fetchReq),
  .fetchValid   (fetchValid),
  .fetchAddr    (fetchAddr),
  .laneValid    (laneValid),
  .laneLen      (laneLen)
);

// File: tb/sim_fetch_align_buf.sv
module sim_fetch_align_buf;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int FB         = 32;
  localparam int LANES      = 3;
  localparam int LB         = 16;
  localparam int MAXI       = 9;
  localparam int MEM        = 4096;
  localparam int WATCHDOG   = 20000;

  // {target[15:0], pattern[3:0], stall[3:0], cycles[7:0]}
  localparam logic [31:0] SCEN [7] = '{
    32'h0040_0018,  // 9-byte run, aligned, no stall
    32'h010B_2014,  // lengths 1..9, offset 11
    32'h021F_3114,  // 4-byte, offset 31, stall every third cycle
    32'h0300_101E,  // 1-byte, queue fills
    32'h00A5_4014,  // markers every 13 bytes -> 9,4
    32'h01E7_0214,  // 9-byte, offset 7, stall every other cycle
    32'h03F9_2010   // lengths 1..9, offset 25
  };

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  redirectValid = 1'b0;
  logic [ADDR_W-1:0]     redirectAddr = '0;
  logic                  fetchReq;
  logic [ADDR_W-1:0]     fetchAddr;
  logic                  fetchValid = 1'b0;
  logic [FB*8-1:0]       fetchData = '0;
  logic [FB-1:0]         fetchEnd = '0;
  logic [LANES-1:0]      laneValid;
  logic [LANES*4-1:0]    laneLen;
  logic [LANES*LB*8-1:0] laneBytes;

  fetch_align_buf u0 (
    .clk(clk), .rstN(rstN), .redirectValid(redirectValid), .redirectAddr(redirectAddr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .fetchData(fetchData), .fetchEnd(fetchEnd), .laneValid(laneValid),
    .laneLen(laneLen), .laneBytes(laneBytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] memByte [MEM];
  logic       memEnd  [MEM];
  int checks = 0;
  int fails  = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  int occ, expPos, expAddr, skipFirst, lastValid;
  bit firstPend, firstEmit;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > WATCHDOG && !done) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycleCnt, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int patLen(input int pat, input int k);
    case (pat)
      0:       return 9;
      1:       return 1;
      2:       return (k % 9) + 1;
      3:       return 4;
      default: return 13;
    endcase
  endfunction

  // Decoy markers below the target; real markers from the target onward.
  task automatic buildProgram(input int target, input int pat);
    int pos, k, l;
    for (int a = 0; a < MEM; a++) memEnd[a] = (a < target);
    pos = target;
    k = 0;
    while (pos < MEM) begin
      l = patLen(pat, k);
      if (pos + l - 1 < MEM) memEnd[pos + l - 1] = 1'b1;
      pos = pos + l;
      k = k + 1;
    end
  endtask

  function automatic int expLen(input int p);
    for (int k = 0; k < MAXI; k++) if (memEnd[(p + k) % MEM]) return k + 1;
    return MAXI;
  endfunction

  task automatic driveCache(input bit v);
    int base;
    base = int'(fetchAddr[11:0]);
    fetchValid = v;
    for (int k = 0; k < FB; k++) begin
      fetchData[k*8 +: 8] = memByte[(base + k) % MEM];
      fetchEnd[k]         = memEnd[(base + k) % MEM];
    end
  endtask

  task automatic stepCycle(input bit redir, input int target, input bit cacheOk);
    int consumed, l, iaddr;
    bit prevOk, eOk, expReq;
    logic [127:0] expBytes;
    string tag;
    @(negedge clk);
    redirectValid = redir;
    redirectAddr  = ADDR_W'(target);
    driveCache(cacheOk);
    #1;
    lastValid = 0;
    if (redir) begin
      check(fetchReq == 1'b0, "R2", "fetchReq during redirect", 128'(fetchReq), 0);
      check(laneValid == '0, "R2", "lanes during redirect", 128'(laneValid), 0);
      occ = 0; expPos = target; expAddr = target & ~31;
      skipFirst = target & 31; firstPend = 1'b1; firstEmit = 1'b1;
    end else begin
      consumed = 0;
      prevOk = 1'b1;
      for (int i = 0; i < LANES; i++) begin
        iaddr = expPos + consumed;
        l = expLen(iaddr);
        eOk = prevOk && (l <= occ - consumed);
        check(laneValid[i] == eOk, "R7", $sformatf("lane %0d valid (R8 order)", i),
              128'(laneValid[i]), 128'(eOk));
        if (eOk && laneValid[i]) begin
          check(laneLen[i*4 +: 4] == 4'(l), "R6", $sformatf("lane %0d length", i),
                128'(laneLen[i*4 +: 4]), 128'(l));
          expBytes = '0;
          for (int k = 0; k < LB; k++)
            if (k < l) expBytes[k*8 +: 8] = memByte[(iaddr + k) % MEM];
          if (firstEmit && skipFirst != 0) tag = "R3";
          else if ((iaddr / 32) != ((iaddr + l - 1) / 32)) tag = "R10";
          else tag = "R9";
          check(laneBytes[i*128 +: 128] == expBytes, tag, $sformatf("lane %0d bytes", i),
                laneBytes[i*128 +: 128], expBytes);
          firstEmit = 1'b0;
          consumed = consumed + l;
          lastValid = lastValid + 1;
        end
        prevOk = eOk;
      end
      expReq = (occ - consumed) <= 32;
      check(fetchReq == expReq, "R5", "fetchReq vs free space", 128'(fetchReq), 128'(expReq));
      if (fetchReq && cacheOk) begin
        check(fetchAddr == ADDR_W'(expAddr), "R4", "fetch address", 128'(fetchAddr), 128'(expAddr));
        occ = occ - consumed + 32 - (firstPend ? skipFirst : 0);
        expAddr = expAddr + 32;
        firstPend = 1'b0;
      end else begin
        occ = occ - consumed;
      end
      expPos = expPos + consumed;
    end
  endtask

  task automatic runScenario(input int target, input int pat, input int stall,
                             input int ncyc, input bit doubleRedir);
    bit started, allThree, sawFull, ok;
    buildProgram(target, pat);
    if (doubleRedir) stepCycle(1'b1, (target + 300) % MEM, 1'b1);
    stepCycle(1'b1, target, 1'b1);
    started = 1'b0; allThree = 1'b1; sawFull = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      ok = (stall == 0) ? 1'b1 : (stall == 1) ? (c % 3 != 2) : (c % 2 == 0);
      stepCycle(1'b0, 0, ok);
      if (!fetchReq) sawFull = 1'b1;
      if (lastValid > 0) started = 1'b1;
      if (started && lastValid != 3) allThree = 1'b0;
    end
    if (pat == 0 && stall == 0 && (target % 32) == 0)
      check(allThree, "R11", "three lanes every cycle", 128'(allThree), 1);
    if (pat == 1)
      check(sawFull, "R5", "back-pressure seen", 128'(sawFull), 1);
  endtask

  initial begin
    for (int a = 0; a < MEM; a++) begin
      memByte[a] = 8'((a * 29 + a / 7 + 3) & 255);
      memEnd[a]  = 1'b1;
    end
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetchReq == 1'b0, "R1", "fetchReq in reset", 128'(fetchReq), 0);
    check(laneValid == '0, "R1", "lanes in reset", 128'(laneValid), 0);
    rstN = 1'b1;
    // R1: idle until the first redirect, even with the cache offering data
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      driveCache(1'b1);
      #1;
      check(fetchReq == 1'b0, "R1", "idle fetchReq", 128'(fetchReq), 0);
      check(laneValid == '0, "R1", "idle lanes", 128'(laneValid), 0);
    end
    for (int s = 0; s < 7; s++)
      runScenario(int'(SCEN[s][31:16]), int'(SCEN[s][15:12]), int'(SCEN[s][11:8]),
                  int'(SCEN[s][7:0]), 1'b0);
    // R2: back-to-back redirects, only the second target counts
    runScenario(32'h0123, 3, 0, 12, 1'b1);
    // R2: queue empty the cycle after a redirect
    stepCycle(1'b1, 32'h0200, 1'b1);
    @(negedge clk);
    redirectValid = 1'b0;
    fetchValid = 1'b0;
    #1;
    check(laneValid == '0, "R2", "lanes after flush", 128'(laneValid), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule